// File: doc/BRIEF.md
# Section Trace Byte Monitor

This block watches the section trace byte that a receive framer delivers once per frame. A one-cycle strobe marks each new trace byte. A 3-bit mode input selects one of six behaviours. The first learns a repeating 16-byte message and flags any byte that differs from the byte seen 16 frames earlier. Two modes find the start of the message from a marker byte: 0x0A in the SONET style, or a byte with its top bit set in the SDH style. Once aligned, they compare each byte against the byte stored earlier at the same position. One mode accepts a single trace byte only after it has repeated for a programmable number of frames. Two modes compare the incoming message against 16 bytes written by software, using either of the two alignment styles.

The block reports a mismatch state bit and a sticky delta flag, which is set whenever the mismatch state changes or, in persistence mode, whenever a new byte is accepted. The interrupt output is the delta flag gated by a mask input. A small register port gives read access to the captured array and the status, and read/write access to the expected array. A write of 1 to the delta bit clears the delta flag.

Top module: `trace_mon`

## Requirements
- R1: In mode 000, each strobed byte is compared with the captured entry at the current index, modulo 16, then written into that entry, and the index advances. A difference sets the mismatch state.
- R2: The mismatch state clears at the end of a 16-byte pass, meaning the byte at index 15, when no byte in that pass differed.
- R3: In mode 001 the block is unaligned until a 0x0A byte arrives. The byte after the marker goes to index 0. While unaligned, bytes are neither stored nor compared.
- R4: In mode 010 a byte with bit 7 set is the marker. The byte after it goes to index 1, and the mode otherwise behaves like mode 001.
- R5: In an aligned mode 001 or 010, a byte that differs from the captured byte at its index sets the mismatch state, and the new byte is stored at that index.
- R6: Modes 100 and 101 align like modes 001 and 010 respectively, but compare against the expected array and leave the captured array untouched. A difference sets the mismatch state.
- R7: In mode 011 the candidate count restarts at 1 on any new byte. When the count reaches the threshold (a threshold of 0 acts as 1) and the byte differs from captured entry 0, the byte is written to entry 0 and delta is set. The mismatch state does not change in this mode.
- R8: Delta is set on any change of the mismatch state and stays set until a register write with data bit 1 set to status address 0x20. Irq is high exactly when delta and irq_mask are both high.
- R9: Modes 110 and 111 change no captured entry, mismatch state or delta.
- R10: A change of the mode input resets the index, the alignment and the persistence count. No byte is processed in that cycle.
- R11: Register map: 0x00–0x0F read the captured entries, 0x10–0x1F read and write the expected entries, and 0x20 reads {delta in bit 1, mismatch in bit 0}. After reset, all entries, mismatch and delta are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe, one new trace byte per frame |
| trace_in | input | 8 | Received trace byte |
| mode | input | 3 | Monitoring mode select |
| persist_thr | input | 4 | Consecutive-frame threshold for mode 011 |
| irq_mask | input | 1 | Enables the interrupt |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| mismatch | output | 1 | Trace mismatch state |
| delta | output | 1 | Sticky change flag |
| irq | output | 1 | Masked interrupt |

## Verification
A stale index or a lost alignment shows up as a byte written to the wrong captured entry. A register read immediately after the frame therefore places each stored byte, and the tests read specific entries right after marker bytes. A pass-tracking flag that fails to clear or to set is only visible at the index-15 byte, so the bench checks the mismatch bit exactly after whole passes and after single corrupted bytes. A wrong persistence count appears as entry 0 changing one frame early or late, so the bench checks acceptance frame by frame.

// File: rtl/trace_mon.sv
module trace_mon #(
  parameter int BYTE_W  = 8,
  parameter int MSG_LEN = 16,
  parameter int THR_W   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_stb,
  input  logic [BYTE_W-1:0]           trace_in,
  input  logic [2:0]                  mode,
  input  logic [THR_W-1:0]            persist_thr,
  input  logic                        irq_mask,
  input  logic                        reg_we,
  input  logic [$clog2(MSG_LEN)+1:0]  reg_addr,
  input  logic [BYTE_W-1:0]           reg_wdata,
  output logic [BYTE_W-1:0]           reg_rdata,
  output logic                        mismatch,
  output logic                        delta,
  output logic                        irq
);
  localparam int IDX_W = $clog2(MSG_LEN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(MSG_LEN - 1);
  localparam logic [BYTE_W-1:0] SONET_MARK = BYTE_W'(8'h0A);
  localparam logic [IDX_W+1:0] STAT_ADDR = {2'b10, {IDX_W{1'b0}}};

  logic [BYTE_W-1:0] cap  [MSG_LEN];
  logic [BYTE_W-1:0] expv [MSG_LEN];
  logic [IDX_W-1:0]  idx;
  logic              aligned, bad, mism, dlt;
  logic [2:0]        mode_q;
  logic [BYTE_W-1:0] cand;
  logic [THR_W-1:0]  cnt;

  wire mode_chg = mode != mode_q;
  wire learn    = mode == 3'b000;
  wire sonet_m  = mode == 3'b001 || mode == 3'b100;
  wire sdh_m    = mode == 3'b010 || mode == 3'b101;
  wire align_m  = sonet_m || sdh_m;
  wire expm     = mode[2] && !mode[1];
  wire persist  = mode == 3'b011;
  wire go       = frame_stb && !mode_chg;

  wire is_mark  = sonet_m ? (trace_in == SONET_MARK) : trace_in[BYTE_W-1];
  wire at_end   = idx == LAST;
  wire [IDX_W-1:0] idx_adv = at_end ? '0 : idx + 1'b1;
  wire [BYTE_W-1:0] ref_b = expm ? expv[idx] : cap[idx];
  wire diff     = trace_in != ref_b;
  wire cmp_on   = go && (learn || (align_m && aligned));
  wire bad_nxt  = at_end ? 1'b0 : (bad || diff);

  logic mism_nxt;
  always_comb begin
    mism_nxt = mism;
    if (cmp_on) begin
      if (diff) mism_nxt = 1'b1;
      else if (at_end && !bad) mism_nxt = 1'b0;
    end
  end

  wire [THR_W-1:0] thr_eff = (persist_thr == '0) ? THR_W'(1) : persist_thr;
  wire [THR_W-1:0] cnt_nxt = (trace_in != cand) ? THR_W'(1) :
                             (&cnt) ? cnt : cnt + 1'b1;
  wire accept    = go && persist && (cnt_nxt >= thr_eff) && (trace_in != cap[0]);
  wire delta_set = (mism_nxt != mism) || accept;
  wire delta_clr = reg_we && reg_addr == STAT_ADDR && reg_wdata[1];
  wire exp_we    = reg_we && reg_addr[IDX_W+1:IDX_W] == 2'b01;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MSG_LEN; i++) begin
        cap[i]  <= '0;
        expv[i] <= '0;
      end
      idx <= '0; aligned <= 1'b0; bad <= 1'b0; mism <= 1'b0; dlt <= 1'b0;
      mode_q <= 3'b000; cand <= '0; cnt <= '0;
    end else begin
      mode_q <= mode;
      mism   <= mism_nxt;
      if (delta_set) dlt <= 1'b1;
      else if (delta_clr) dlt <= 1'b0;
      if (exp_we) expv[reg_addr[IDX_W-1:0]] <= reg_wdata;
      if (mode_chg) begin
        idx <= '0; aligned <= 1'b0; bad <= 1'b0; cnt <= '0;
      end else if (frame_stb) begin
        if (persist) begin
          cand <= trace_in;
          cnt  <= cnt_nxt;
          if (accept) cap[0] <= trace_in;
        end else if (learn) begin
          cap[idx] <= trace_in;
          idx      <= idx_adv;
          bad      <= bad_nxt;
        end else if (align_m) begin
          if (aligned) begin
            if (!expm) cap[idx] <= trace_in;
            bad <= bad_nxt;
          end
          if (is_mark) begin
            aligned <= 1'b1;
            idx     <= sdh_m ? IDX_W'(1) : '0;
          end else if (aligned) begin
            idx <= idx_adv;
          end
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr[IDX_W+1:IDX_W])
      2'b00: reg_rdata = cap[reg_addr[IDX_W-1:0]];
      2'b01: reg_rdata = expv[reg_addr[IDX_W-1:0]];
      2'b10: if (reg_addr[IDX_W-1:0] == '0) reg_rdata = BYTE_W'({dlt, mism});
      default: reg_rdata = '0;
    endcase
  end

  assign mismatch = mism;
  assign delta    = dlt;
  assign irq      = dlt && irq_mask;
endmodule

// File: rtl/trace_mon_chk.sv
module trace_mon_chk #(
  parameter int AW = 6,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_stb,
  input logic [2:0]    mode,
  input logic          irq_mask,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [BW-1:0] reg_wdata,
  input logic          mismatch,
  input logic          delta,
  input logic          irq
);
  wire clr_wr = reg_we && reg_addr == {2'b10, {(AW-2){1'b0}}} && reg_wdata[1];

  AST_MISM_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(mismatch)) else $error("mismatch moved without strobe"); // R1

  AST_UNDEF_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mode[2:1] == 2'b11 |=> $stable(mismatch)) else $error("undefined mode changed state"); // R9

  AST_PERSIST_NO_MISM: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'b011 |=> $stable(mismatch)) else $error("persist mode changed mismatch"); // R7

  AST_DELTA_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mismatch) |-> delta) else $error("change without delta"); // R8

  AST_DELTA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (delta && !clr_wr) |=> delta) else $error("delta dropped"); // R8

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask |-> !irq) else $error("irq while masked"); // R8
endmodule

bind trace_mon trace_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mode(mode),
  .irq_mask(irq_mask), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mismatch(mismatch), .delta(delta), .irq(irq)
);

// File: tb/trace_mon_tb.sv
module trace_mon_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_stb = 1'b0;
  logic [7:0] trace_in = '0;
  logic [2:0] mode = 3'b000;
  logic [3:0] persist_thr = 4'd3;
  logic       irq_mask = 1'b0;
  logic       reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       mismatch, delta, irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trace_mon u_dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .trace_in(trace_in),
    .mode(mode), .persist_thr(persist_thr), .irq_mask(irq_mask),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mismatch(mismatch), .delta(delta), .irq(irq)
  );

  // {repeat, byte, expected mismatch, expected delta}, mode 000 from reset
  localparam logic [14:0] VEC [5] = '{
    {5'd16, 8'h00, 1'b0, 1'b0},
    {5'd1,  8'h41, 1'b1, 1'b1},
    {5'd15, 8'h00, 1'b1, 1'b1},
    {5'd1,  8'h41, 1'b1, 1'b1},
    {5'd15, 8'h00, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic frame(input logic [7:0] b);
    @(negedge clk);
    trace_in = b; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk);
    mode = m;
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 mismatch", mismatch, 0);
    chk("R11 delta", delta, 0);
    rd(6'h20, d); chk("R11 status", d, 0);
    rd(6'h05, d); chk("R11 captured entry", d, 0);

    // R1 R2 table walk
    foreach (VEC[i]) begin
      for (int k = 0; k < int'(VEC[i][14:10]); k++) frame(VEC[i][9:2]);
      chk("R1/R2 table mismatch", mismatch, VEC[i][1]);
      chk("R8 table delta", delta, VEC[i][0]);
    end
    rd(6'h00, d); chk("R1 captured entry 0", d, 8'h41);

    // R8 mask and clear
    chk("R8 irq masked", irq, 0);
    irq_mask = 1'b1; #1;
    chk("R8 irq unmasked", irq, 1);
    wr(6'h20, 8'h01);
    chk("R8 write without bit1 keeps delta", delta, 1);
    wr(6'h20, 8'h02);
    chk("R8 delta cleared", delta, 0);
    chk("R8 irq after clear", irq, 0);

    // R3 SONET alignment
    set_mode(3'b001);
    frame(8'h55); frame(8'h55);
    rd(6'h01, d); chk("R3 unaligned not stored", d, 0);
    chk("R3 unaligned not compared", mismatch, 0);
    frame(8'h0A);
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 15; i++) frame(8'h50 + 8'(i));
      frame(8'h0A);
      if (p == 0) chk("R5 first pass mismatch", mismatch, 1);
    end
    chk("R2 clean pass clears", mismatch, 0);
    rd(6'h00, d); chk("R3 byte after marker at 0", d, 8'h50);
    rd(6'h0F, d); chk("R3 marker at 15", d, 8'h0A);
    frame(8'h50); frame(8'h51); frame(8'h52);
    chk("R5 matching bytes", mismatch, 0);
    frame(8'hFF);
    chk("R5 differing byte", mismatch, 1);
    rd(6'h03, d); chk("R5 byte stored", d, 8'hFF);

    // R4 SDH alignment
    set_mode(3'b010);
    frame(8'h11);
    rd(6'h01, d); chk("R4 unaligned not stored", d, 8'h51);
    frame(8'hD3); frame(8'h61);
    rd(6'h01, d); chk("R4 byte after marker at 1", d, 8'h61);
    for (int i = 2; i < 16; i++) frame(8'h60 + 8'(i));
    frame(8'hD3);
    rd(6'h00, d); chk("R4 aligned marker at 0", d, 8'hD3);

    // R6 expected compare, SONET alignment
    for (int i = 0; i < 15; i++) wr(6'h10 + 6'(i), 8'h30 + 8'(i));
    wr(6'h1F, 8'h0A);
    rd(6'h12, d); chk("R11 expected readback", d, 8'h32);
    set_mode(3'b100);
    frame(8'h0A);
    for (int i = 0; i < 15; i++) frame(8'h30 + 8'(i));
    frame(8'h0A);
    chk("R6 sonet expected match", mismatch, 0);
    rd(6'h02, d); chk("R6 captured untouched", d, 8'h62);
    wr(6'h20, 8'h02);
    frame(8'h00);
    chk("R6 sonet expected differ", mismatch, 1);
    chk("R8 delta on rise", delta, 1);

    // R6 expected compare, SDH alignment
    wr(6'h10, 8'hB0);
    set_mode(3'b101);
    frame(8'hB0);
    for (int i = 1; i < 15; i++) frame(8'h30 + 8'(i));
    frame(8'h0A);
    chk("R6 sdh expected match", mismatch, 0);
    frame(8'hB0);
    frame(8'h99);
    chk("R6 sdh expected differ", mismatch, 1);

    // R7 persistence
    persist_thr = 4'd3;
    set_mode(3'b011);
    wr(6'h20, 8'h02);
    frame(8'h77); frame(8'h77);
    rd(6'h00, d); chk("R7 below threshold", d, 8'hD3);
    frame(8'h12); frame(8'h77); frame(8'h77);
    rd(6'h00, d); chk("R7 count restarted", d, 8'hD3);
    chk("R7 no delta yet", delta, 0);
    frame(8'h77);
    rd(6'h00, d); chk("R7 accepted", d, 8'h77);
    chk("R7 delta on accept", delta, 1);
    chk("R7 mismatch unused", mismatch, 1);
    persist_thr = 4'd0;
    wr(6'h20, 8'h02);
    frame(8'h88);
    rd(6'h00, d); chk("R7 threshold zero as one", d, 8'h88);

    // R10 mode change resets persistence count
    persist_thr = 4'd3;
    frame(8'h5A); frame(8'h5A);
    set_mode(3'b110);
    set_mode(3'b011);
    frame(8'h5A);
    rd(6'h00, d); chk("R10 count reset on mode change", d, 8'h88);

    // R9 undefined modes
    set_mode(3'b110);
    wr(6'h20, 8'h02);
    frame(8'h00); frame(8'h8F); frame(8'h0A);
    rd(6'h00, d); chk("R9 entry unchanged", d, 8'h88);
    chk("R9 mismatch unchanged", mismatch, 1);
    chk("R9 delta unchanged", delta, 0);
    set_mode(3'b111);
    frame(8'h44);
    rd(6'h00, d); chk("R9 mode 111 entry unchanged", d, 8'h88);

    // R10 mode change resets index
    set_mode(3'b000);
    frame(8'hEE);
    rd(6'h00, d); chk("R10 index reset on mode change", d, 8'hEE);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule